// File: doc/BRIEF.md
# IR Pulse-Width Capture Receiver

This block times the marks and spaces on a digital infrared line. The line is either the external receiver input or, for self-test, the local transmitter output. It passes through a two-flop synchroniser and an optional glitch filter. A pulse timer then counts ticks from a programmable clock divider between the edges chosen by the edge-select field. Each finished interval becomes one record in a small receive queue. A record holds a width count and a level bit. When the timer runs past its count range, it stops and may leave a distinct timeout record.

Software, or a downstream engine, pops records through a show-ahead read port. The status outputs report a timeout, a queue overrun, an active timer and a service request. The service request follows one of two fill thresholds. Each of the three interrupt sources has its own enable, and the enabled sources are combined onto a single request line.

Top module: `irpw_rx_top`

## Requirements
- R1: The line being timed is `tx_loop_in` when `cfg_loopback` is 1 and `ir_in` when it is 0. The line that is not selected has no effect on records or on `st_busy`.
- R2: `cfg_edge` selects the timing edges: 0 = none, 1 = falling, 2 = rising, 3 = both. With 3, every mark and every space after the first edge produces one record. The level bit is 1 for a mark (line high) and 0 for a space.
- R3: With 2, one record covers the interval between two consecutive rising edges, with level bit 0. With 1, one record covers the interval between two consecutive falling edges, with level bit 1. With 0, no record is written and `st_busy` stays 0.
- R4: For an interval of W clock cycles, the count field is floor(W / (`cfg_div` + 1)). The first selected edge after enable only starts the timer and writes no record.
- R5: A record is `rd_data` = {timeout flag [COUNT_W+1], level [COUNT_W], count [COUNT_W-1:0]}. The timeout record is flag 1, level 0, count all ones. A normal record has flag 0.
- R6: When the count would pass its all-ones value, the timer stops (`st_busy` goes to 0) and `st_timeout` is set. The timeout record is written only when `cfg_ovf_marker` is 1. When it is 0, nothing is written.
- R7: When `cfg_filt` is N > 1, a level held for fewer than N cycles is ignored, and accepted edges are delayed uniformly, so widths are kept. When N is 0 or 1, the filter is bypassed.
- R8: `cfg_inv` = 1 inverts the level bit of normal records. It does not affect timeout records.
- R9: The queue holds DEPTH (8) records in arrival order. `rd_data` shows the oldest record, and `rd_en` removes it. `rd_en` on an empty queue changes nothing.
- R10: A record arriving at a full queue is discarded and sets sticky `st_overrun`. A one-cycle `st_clr` pulse clears both `st_overrun` and `st_timeout`.
- R11: `st_service` equals "queue not empty" when `cfg_wm_half` is 0. It equals "level >= DEPTH/2" when `cfg_wm_half` is 1.
- R12: `irq` = (`ie_srv` & `st_service`) | (`ie_tmo` & `st_timeout`) | (`ie_ovr` & `st_overrun`).
- R13: While `cfg_en` is 0, the timer, divider and edge state are held idle. An interval cut short by disabling writes no record.
- R14: `st_busy` is 1 from the first selected edge until the timer overflows or is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Receiver enable |
| cfg_div | input | DIV_W | Tick period minus one, in clock cycles |
| cfg_edge | input | 2 | Timing edge select |
| cfg_inv | input | 1 | Invert recorded level bit |
| cfg_filt | input | FILT_W | Minimum accepted level duration, in cycles |
| cfg_ovf_marker | input | 1 | Write a timeout record on overflow |
| cfg_wm_half | input | 1 | Service threshold: half full instead of not empty |
| cfg_loopback | input | 1 | Time the transmitter line instead of the external input |
| ie_srv | input | 1 | Service interrupt enable |
| ie_tmo | input | 1 | Timeout interrupt enable |
| ie_ovr | input | 1 | Overrun interrupt enable |
| st_clr | input | 1 | Clear sticky timeout and overrun flags |
| ir_in | input | 1 | External IR level |
| tx_loop_in | input | 1 | Transmitter level for loopback |
| rd_en | input | 1 | Pop the oldest record |
| rd_data | output | COUNT_W+2 | Oldest record |
| rd_empty | output | 1 | Queue empty |
| rd_level | output | $clog2(DEPTH+1) | Records held |
| st_timeout | output | 1 | Sticky timer overflow |
| st_overrun | output | 1 | Sticky queue overrun |
| st_busy | output | 1 | Timer running |
| st_service | output | 1 | Service threshold reached |
| irq | output | 1 | Combined interrupt request |

## Verification
Pseudo-random mark/space trains are timed with random edge modes, divider values and inversion, and the counts and level bits are compared against a floor-division model. This separates off-by-one tick accounting and wrong level attribution. Directed trains then cover the remaining behaviour. A train containing a two-cycle glitch is run with and without the filter, so merged and split intervals give different records. Long idle tails reach overflow under both marker settings, which tells the marker record apart from a silent stop. A train too long for the queue, fill levels just either side of half full, and a train on the unselected input check the drop, threshold and loopback paths.

// File: rtl/irpw_pkg.sv
package irpw_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    localparam int DEF_COUNT_W = 16;
    localparam int DEF_DIV_W   = 16;
    localparam int DEF_FILT_W  = 8;
    localparam int DEF_DEPTH   = 8;

    typedef struct packed {
        logic timeout;
        logic overrun;
        logic busy;
        logic service;
    } rx_status_t;

    function automatic logic edge_hit(edge_mode_e mode, logic prev, logic cur);
        case (mode)
            EDGE_FALL: return prev & ~cur;
            EDGE_RISE: return ~prev & cur;
            EDGE_BOTH: return prev ^ cur;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irpw_front.sv
module irpw_front #(
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              raw_in,
    input  logic [FILT_W-1:0] min_width,
    output logic              lvl_o
);
    logic [1:0]        sync_q;
    logic [FILT_W-1:0] run_q;
    logic              lvl_q;
    logic              differ;
    logic              accept;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[0], raw_in};
    end

    assign differ = (sync_q[1] != lvl_q);
    assign accept = ({1'b0, run_q} + (FILT_W+1)'(1)) >= {1'b0, min_width};

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else if (!en) begin
            lvl_q <= sync_q[1];
            run_q <= '0;
        end else if (differ) begin
            if (accept) begin
                lvl_q <= sync_q[1];
                run_q <= '0;
            end else begin
                run_q <= run_q + FILT_W'(1);
            end
        end else begin
            run_q <= '0;
        end
    end

    assign lvl_o = lvl_q;

    // R7: with the filter bypassed a new level is taken on the next edge
    a_r7_bypass_follow: assert property (@(posedge clk) disable iff (rst)
        (en && min_width == '0 && differ) |=> (lvl_o == $past(sync_q[1])));

endmodule

// File: rtl/irpw_divider.sv
module irpw_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + DIV_W'(1);
    end

endmodule

// File: rtl/irpw_timer.sv
module irpw_timer
    import irpw_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  edge_mode_e         mode,
    input  logic               lvl,
    input  logic               inv,
    input  logic               keep_marker,
    input  logic               tick,
    output logic               div_clr,
    output logic               push,
    output logic               push_tmo,
    output logic               push_lvl,
    output logic [COUNT_W-1:0] push_cnt,
    output logic               busy,
    output logic               ovf
);
    localparam logic [COUNT_W-1:0] CNT_MAX = '1;

    logic               prev_q;
    logic               active_q;
    logic [COUNT_W-1:0] cnt_q;
    logic               hit;
    logic               at_max;

    assign hit     = en && edge_hit(mode, prev_q, lvl);
    assign at_max  = (cnt_q == CNT_MAX);
    assign ovf     = en && active_q && !hit && tick && at_max;
    assign div_clr = !en || !active_q || hit;

    assign push     = (hit && active_q) || (ovf && keep_marker);
    assign push_tmo = ovf;
    assign push_lvl = ovf ? 1'b0 : (prev_q ^ inv);
    assign push_cnt = ovf ? CNT_MAX :
                      ((tick && !at_max) ? cnt_q + COUNT_W'(1) : cnt_q);
    assign busy     = active_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (hit) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q && tick) begin
            if (at_max) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + COUNT_W'(1);
            end
        end
    end

    a_r6_stop_on_ovf: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !busy);
    a_r13_off_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);
    a_r3_none_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == EDGE_OFF && !busy) |=> !busy);
    a_r14_busy_needs_en: assert property (@(posedge clk) disable iff (rst)
        busy |-> $past(en));

endmodule

// File: rtl/irpw_fifo.sv
module irpw_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 18,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic          drop,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q;
    logic [AW-1:0] rp_q;
    logic [LW-1:0] lvl_q;
    logic          wr;
    logic          rd;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty = (lvl_q == '0);
    assign full  = (lvl_q == LW'(DEPTH));
    assign wr    = push && !full;
    assign rd    = pop && !empty;
    assign drop  = push && full;
    assign dout  = mem_q[rp_q];
    assign level = lvl_q;

    always_ff @(posedge clk) begin
        if (wr) mem_q[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (wr) wp_q <= bump(wp_q);
            if (rd) rp_q <= bump(rp_q);
            case ({wr, rd})
                2'b10:   lvl_q <= lvl_q + LW'(1);
                2'b01:   lvl_q <= lvl_q - LW'(1);
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= LW'(DEPTH));
    a_r9_pop_empty_ignored: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);
    a_r10_drop_keeps_full: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/irpw_rx_top.sv
module irpw_rx_top
    import irpw_pkg::*;
#(
    parameter int COUNT_W = DEF_COUNT_W,
    parameter int DIV_W   = DEF_DIV_W,
    parameter int FILT_W  = DEF_FILT_W,
    parameter int DEPTH   = DEF_DEPTH,
    localparam int REC_W  = COUNT_W + 2,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_edge,
    input  logic              cfg_inv,
    input  logic [FILT_W-1:0] cfg_filt,
    input  logic              cfg_ovf_marker,
    input  logic              cfg_wm_half,
    input  logic              cfg_loopback,
    input  logic              ie_srv,
    input  logic              ie_tmo,
    input  logic              ie_ovr,
    input  logic              st_clr,
    input  logic              ir_in,
    input  logic              tx_loop_in,
    input  logic              rd_en,
    output logic [REC_W-1:0]  rd_data,
    output logic              rd_empty,
    output logic [LW-1:0]     rd_level,
    output logic              st_timeout,
    output logic              st_overrun,
    output logic              st_busy,
    output logic              st_service,
    output logic              irq
);
    localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);

    logic               src;
    logic               flt_lvl;
    logic               tick;
    logic               div_clr;
    logic               t_push;
    logic               t_tmo;
    logic               t_lvl;
    logic [COUNT_W-1:0] t_cnt;
    logic               t_busy;
    logic               t_ovf;
    logic               q_full;
    logic               q_drop;
    rx_status_t         stat_q;
    rx_status_t         stat;

    assign src = cfg_loopback ? tx_loop_in : ir_in;

    irpw_front #(.FILT_W(FILT_W)) u_front (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_en),
        .raw_in    (src),
        .min_width (cfg_filt),
        .lvl_o     (flt_lvl)
    );

    irpw_divider #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (div_clr),
        .div  (cfg_div),
        .tick (tick)
    );

    irpw_timer #(.COUNT_W(COUNT_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .en          (cfg_en),
        .mode        (edge_mode_e'(cfg_edge)),
        .lvl         (flt_lvl),
        .inv         (cfg_inv),
        .keep_marker (cfg_ovf_marker),
        .tick        (tick),
        .div_clr     (div_clr),
        .push        (t_push),
        .push_tmo    (t_tmo),
        .push_lvl    (t_lvl),
        .push_cnt    (t_cnt),
        .busy        (t_busy),
        .ovf         (t_ovf)
    );

    irpw_fifo #(.DEPTH(DEPTH), .W(REC_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (t_push),
        .din   ({t_tmo, t_lvl, t_cnt}),
        .pop   (rd_en),
        .dout  (rd_data),
        .empty (rd_empty),
        .full  (q_full),
        .drop  (q_drop),
        .level (rd_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.timeout <= (stat_q.timeout && !st_clr) || t_ovf;
            stat_q.overrun <= (stat_q.overrun && !st_clr) || q_drop;
            stat_q.busy    <= 1'b0;
            stat_q.service <= 1'b0;
        end
    end

    always_comb begin
        stat         = stat_q;
        stat.busy    = t_busy;
        stat.service = cfg_wm_half ? (rd_level >= HALF) : !rd_empty;
    end

    assign st_timeout = stat.timeout;
    assign st_overrun = stat.overrun;
    assign st_busy    = stat.busy;
    assign st_service = stat.service;
    assign irq = (ie_srv && stat.service) || (ie_tmo && stat.timeout) ||
                 (ie_ovr && stat.overrun);

    a_r6_timeout_flag: assert property (@(posedge clk) disable iff (rst)
        t_ovf |=> st_timeout);
    a_r10_drop_flags: assert property (@(posedge clk) disable iff (rst)
        (q_drop && q_full) |=> st_overrun);
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (st_clr && !q_drop) |=> !st_overrun);
    a_r11_nonempty_irq: assert property (@(posedge clk) disable iff (rst)
        (ie_srv && !cfg_wm_half && !rd_empty) |-> irq);
    a_r12_timeout_irq: assert property (@(posedge clk) disable iff (rst)
        (ie_tmo && st_timeout) |-> irq);

endmodule

// File: tb/tb_irpw_rx_top.sv
module tb_irpw_rx_top;
    localparam int CW    = 10;
    localparam int RW    = CW + 2;
    localparam int LW    = 4;
    localparam int MAXC  = (1 << CW) - 1;
    localparam logic [RW-1:0] MARKER = {1'b1, 1'b0, {CW{1'b1}}};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          cfg_en = 1'b0;
    logic [15:0]   cfg_div = '0;
    logic [1:0]    cfg_edge = '0;
    logic          cfg_inv = 1'b0;
    logic [7:0]    cfg_filt = '0;
    logic          cfg_ovf_marker = 1'b0;
    logic          cfg_wm_half = 1'b0;
    logic          cfg_loopback = 1'b0;
    logic          ie_srv = 1'b0, ie_tmo = 1'b0, ie_ovr = 1'b0;
    logic          st_clr = 1'b0;
    logic          ir_in = 1'b0, tx_loop_in = 1'b0;
    logic          rd_en = 1'b0;
    logic [RW-1:0] rd_data;
    logic          rd_empty;
    logic [LW-1:0] rd_level;
    logic          st_timeout, st_overrun, st_busy, st_service, irq;

    irpw_rx_top #(.COUNT_W(CW)) dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_div(cfg_div),
        .cfg_edge(cfg_edge), .cfg_inv(cfg_inv), .cfg_filt(cfg_filt),
        .cfg_ovf_marker(cfg_ovf_marker), .cfg_wm_half(cfg_wm_half),
        .cfg_loopback(cfg_loopback), .ie_srv(ie_srv), .ie_tmo(ie_tmo),
        .ie_ovr(ie_ovr), .st_clr(st_clr), .ir_in(ir_in),
        .tx_loop_in(tx_loop_in), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty), .rd_level(rd_level), .st_timeout(st_timeout),
        .st_overrun(st_overrun), .st_busy(st_busy), .st_service(st_service),
        .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    int dur[32];
    int ndur;
    logic [RW-1:0] expq[$];
    bit done = 1'b0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // model of R2/R3/R4/R5/R8: records between consecutive selected edges
    function automatic void build_exp(int mode, int d, bit inv);
        int st[32];
        int acc;
        int last;
        bit rise;
        bit sel;
        int c;
        acc = 0;
        last = -1;
        expq.delete();
        for (int j = 0; j < ndur; j++) begin
            st[j] = acc;
            acc += dur[j];
        end
        for (int j = 0; j < ndur; j++) begin
            rise = (j % 2 == 0);
            sel  = (mode == 3) || (mode == 2 && rise) || (mode == 1 && !rise);
            if (sel) begin
                if (last >= 0) begin
                    c = (st[j] - st[last]) / (d + 1);
                    if (c > MAXC) c = MAXC;
                    expq.push_back({1'b0, (rise ? 1'b0 : 1'b1) ^ inv, CW'(c)});
                end
                last = j;
            end
        end
    endfunction

    task automatic setup(int mode, int d, bit inv, int filt, bit mk);
        cfg_en = 1'b0;
        cycles(3);
        cfg_edge = 2'(mode);
        cfg_div = 16'(d);
        cfg_inv = inv;
        cfg_filt = 8'(filt);
        cfg_ovf_marker = mk;
        cycles(2);
        cfg_en = 1'b1;
        cycles(6);
    endtask

    task automatic play(bit on_loop);
        for (int j = 0; j < ndur; j++) begin
            if (on_loop) tx_loop_in = (j % 2 == 0);
            else         ir_in = (j % 2 == 0);
            cycles(dur[j]);
        end
        ir_in = 1'b0;
        tx_loop_in = 1'b0;
    endtask

    task automatic finish_disable(string req);
        cycles(20);
        chk({req, " R14 busy while timing"}, st_busy, 1);
        cfg_en = 1'b0;
        cycles(2);
        chk({req, " R13 idle after disable"}, st_busy, 0);
    endtask

    task automatic pop_next(string req);
        logic [RW-1:0] e;
        e = expq.pop_front();
        chk({req, " R9 record present"}, rd_empty, 0);
        chk({req, " record value"}, rd_data, e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain(string req);
        int n;
        n = expq.size();
        chk({req, " R9 level"}, rd_level, (n > 8) ? 8 : n);
        for (int k = 0; k < n && k < 8; k++) pop_next(req);
        expq.delete();
        chk({req, " R9 empty after drain"}, rd_empty, 1);
    endtask

    task automatic pulse_clr();
        st_clr = 1'b1;
        @(negedge clk);
        st_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int mode;
        int d;
        bit inv;
        void'($urandom(32'h1F2E3D4C));
        cycles(5);
        rst = 1'b0;
        cycles(2);

        // reset state
        chk("R9 reset empty", rd_empty, 1);
        chk("R14 reset busy", st_busy, 0);
        chk("R10 reset overrun", st_overrun, 0);
        chk("R6 reset timeout", st_timeout, 0);
        chk("R12 reset irq", irq, 0);

        // both edges, overflow with marker
        ndur = 6;
        dur = '{default: 0};
        dur[0] = 30; dur[1] = 50; dur[2] = 12; dur[3] = 7; dur[4] = 100; dur[5] = 40;
        build_exp(3, 0, 1'b0);
        expq.push_back(MARKER);
        setup(3, 0, 1'b0, 0, 1'b1);
        play(1'b0);
        cycles((MAXC + 3) + 30);
        chk("R6 busy after overflow", st_busy, 0);
        chk("R6 timeout set", st_timeout, 1);
        ie_tmo = 1'b1;
        @(negedge clk);
        chk("R12 timeout irq", irq, 1);
        ie_tmo = 1'b0;
        @(negedge clk);
        chk("R12 masked irq", irq, 0);
        drain("R2 R5 both edges with marker");
        pulse_clr();
        chk("R10 clear timeout", st_timeout, 0);

        // inverted, divided, overflow without marker
        build_exp(3, 2, 1'b1);
        setup(3, 2, 1'b1, 0, 1'b0);
        play(1'b0);
        cycles((MAXC + 3) * 3 + 30);
        chk("R6 timeout no marker", st_timeout, 1);
        drain("R8 R6 inverted no marker");
        pulse_clr();

        // single-edge modes
        build_exp(2, 1, 1'b0);
        setup(2, 1, 1'b0, 0, 1'b0);
        play(1'b0);
        finish_disable("R3 rising");
        drain("R3 rising periods");
        build_exp(1, 0, 1'b0);
        setup(1, 0, 1'b0, 0, 1'b0);
        play(1'b0);
        finish_disable("R3 falling");
        drain("R3 falling periods");

        // timing disabled
        setup(0, 0, 1'b0, 0, 1'b1);
        play(1'b0);
        cycles(20);
        chk("R3 none busy", st_busy, 0);
        chk("R3 none no records", rd_level, 0);
        cfg_en = 1'b0;

        // glitch filter: 2-cycle mark inside a space
        ndur = 6;
        dur[0] = 20; dur[1] = 8; dur[2] = 2; dur[3] = 10; dur[4] = 20; dur[5] = 30;
        build_exp(3, 0, 1'b0);
        setup(3, 0, 1'b0, 0, 1'b0);
        play(1'b0);
        finish_disable("R7 unfiltered");
        drain("R7 unfiltered split");
        setup(3, 0, 1'b0, 5, 1'b0);
        play(1'b0);
        ndur = 4;
        dur[0] = 20; dur[1] = 20; dur[2] = 20; dur[3] = 30;
        build_exp(3, 0, 1'b0);
        finish_disable("R7 filtered");
        drain("R7 filtered merge");

        // loopback: external input ignored, transmitter line timed
        ndur = 4;
        dur[0] = 25; dur[1] = 15; dur[2] = 35; dur[3] = 20;
        cfg_loopback = 1'b1;
        setup(3, 0, 1'b0, 0, 1'b0);
        play(1'b0);
        cycles(20);
        chk("R1 unselected input ignored", rd_level, 0);
        chk("R1 unselected input not busy", st_busy, 0);
        build_exp(3, 0, 1'b0);
        play(1'b1);
        finish_disable("R1 loopback");
        drain("R1 loopback records");
        cfg_loopback = 1'b0;

        // pop on empty ignored
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk("R9 pop empty level", rd_level, 0);
        chk("R9 pop empty flag", rd_empty, 1);

        // overrun
        ndur = 10;
        for (int j = 0; j < 10; j++) dur[j] = 10 + j * 3;
        build_exp(3, 0, 1'b0);
        setup(3, 0, 1'b0, 0, 1'b0);
        play(1'b0);
        finish_disable("R10 overrun");
        chk("R10 overrun set", st_overrun, 1);
        ie_ovr = 1'b1;
        @(negedge clk);
        chk("R12 overrun irq", irq, 1);
        ie_ovr = 1'b0;
        drain("R10 first records kept");
        pulse_clr();
        chk("R10 clear overrun", st_overrun, 0);

        // watermark
        ndur = 4;
        dur[0] = 12; dur[1] = 14; dur[2] = 16; dur[3] = 18;
        build_exp(3, 0, 1'b0);
        setup(3, 0, 1'b0, 0, 1'b0);
        play(1'b0);
        finish_disable("R11 three");
        cfg_wm_half = 1'b1;
        ie_srv = 1'b1;
        @(negedge clk);
        chk("R11 half threshold below", st_service, 0);
        chk("R12 service irq off", irq, 0);
        cfg_wm_half = 1'b0;
        @(negedge clk);
        chk("R11 not empty threshold", st_service, 1);
        chk("R12 service irq on", irq, 1);
        drain("R11 three records");
        ndur = 6;
        dur[4] = 20; dur[5] = 22;
        build_exp(3, 0, 1'b0);
        setup(3, 0, 1'b0, 0, 1'b0);
        play(1'b0);
        finish_disable("R11 five");
        cfg_wm_half = 1'b1;
        @(negedge clk);
        chk("R11 half at five", st_service, 1);
        pop_next("R11 pop");
        chk("R11 half at four", st_service, 1);
        pop_next("R11 pop");
        chk("R11 half at three", st_service, 0);
        drain("R11 remaining");
        cfg_wm_half = 1'b0;
        ie_srv = 1'b0;

        // constrained random trains
        for (int it = 0; it < 6; it++) begin
            mode = $urandom_range(3, 1);
            d    = $urandom_range(3, 0);
            inv  = 1'($urandom_range(1, 0));
            ndur = 2 * $urandom_range(4, 1);
            for (int j = 0; j < ndur; j++) dur[j] = $urandom_range(200, 2);
            build_exp(mode, d, inv);
            setup(mode, d, inv, 0, 1'b1);
            play(1'b0);
            finish_disable("R4 random");
            drain("R4 R2 random counts");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule